// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It turns one command at a time into line activity on an open-drain clock/data pair: a start condition, a stop condition, one byte written with the target's acknowledge captured, one byte read with an acknowledge or not-acknowledge returned, or a bus-clear made of nine clock pulses followed by a stop. Sequencing of whole transfers (addressing, repeated starts, retries) belongs to a controller above it.

All line timing comes from a quarter-bit slot. The slot lasts `quarter_div + 1` clock cycles; the divisor is captured when a command is accepted. Each command is a fixed list of slots, and lines change only at slot boundaries. The block outputs pull-down enables only. A released line floats high through external pull-ups, and the pads sit outside the block.

Top module: `i2c_bit_engine`

## Requirements
- R1: A slot lasts `quarter_div + 1` clock cycles. Lines change only on the accepting edge or on a slot boundary. A command of N slots raises `done` exactly N*(`quarter_div`+1) cycles after the accepting edge. N is 4 for a start or stop, 37 for a write, 29 for a read, 40 for a bus-clear and 1 for a reserved code.
- R2: `scl_oe`/`sda_oe` = 1 pulls the line low and 0 releases it. After reset both enables are 0, `cmd_ready` is 1, `done`, `rx_data` and `rx_nack` are 0, and the lines stay released until the first command.
- R3: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from that edge until the command completes. `done` is high for exactly one cycle, and `cmd_ready` returns in that same cycle. Op codes are 0 start, 1 stop, 2 write, 3 read, 4 bus-clear, and 5 to 7 reserved.
- R4: Start: slot 1 holds the previous levels; slot 2 releases SDA; slot 3 releases SCL; slot 4 pulls SDA low. The command ends with SCL released and SDA low.
- R5: Stop: slot 1 pulls SCL low; slot 2 pulls SDA low; slot 3 releases SCL; slot 4 releases SDA. The command ends with both lines released.
- R6: Write sends `cmd_data` MSB first, four slots per bit: SCL low; SDA set to the bit; SCL released; hold. SDA never changes while SCL is released.
- R7: After the eighth bit, the write releases SDA during SCL low and gives a ninth clock with two released slots. It then pulls SCL low for one slot. `rx_nack` takes the SDA level seen on the edge that ends the second high slot (1 = not acknowledged).
- R8: Read releases SDA and clocks eight bits MSB first, three slots per bit: SCL low; SCL released; hold. SDA is sampled on the edge that ends the first high slot, and the byte appears on `rx_data` when `done` rises.
- R9: After a read, the acknowledge phase runs as follows: SCL low; SDA pulled low if `cmd_nack`=0 or released if 1; SCL released for two slots; then SCL low for one slot.
- R10: Bus-clear releases SDA and gives nine SCL pulses of two low and two released slots each, followed by the stop sequence of R5. It ends with both lines released.
- R11: Reserved op codes 5 to 7 take one slot, leave both lines unchanged and raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Op code (see R3) |
| cmd_data | input | 8 | Byte to write |
| cmd_nack | input | 1 | Read only: 1 returns not-acknowledge |
| quarter_div | input | DIV_W | Slot length minus one, in clock cycles |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last byte read |
| rx_nack | output | 1 | Acknowledge level seen by the last write |

## Verification
Each line level is due a fixed number of cycles after the accepting edge: slot k of a command occupies cycles k*(d+1) to (k+1)*(d+1)-1, and `done` is due in cycle N*(d+1). The bench therefore expands every command into its slot list and repeats each entry d+1 times. It compares both enables, `done` and `cmd_ready` at every falling edge, so an early or late transition shows up as a mismatch in a specific cycle. The received byte and acknowledge are compared in the cycle `done` is high. The bench's target model changes its SDA level only inside slots, well before the edge that samples it.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_nack,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic [7:0]       rx_data,
  output logic             rx_nack
);

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_STOP  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_CLEAR = 3'd4;
  localparam int BN_W = 4;
  localparam int PH_W = 3;
  localparam logic [BN_W-1:0] ACK_BN  = 4'd8;
  localparam logic [BN_W-1:0] STOP_BN = 4'd9;

  logic             busy, done_q, rxn_q, nack_q, scl_lv, sda_lv;
  logic [2:0]       op_q;
  logic [7:0]       tx_q, rx_q;
  logic [DIV_W-1:0] div_q, cnt;
  logic [BN_W-1:0]  bn, last_bn, nxt_bn, e_bn;
  logic [PH_W-1:0]  ph, last_ph, nxt_ph, e_ph;
  logic             accept, tick, grp_end, finish, enter;
  logic [2:0]       e_op;
  logic [7:0]       e_tx;
  logic             e_nack;
  logic             set_scl, val_scl, set_sda, val_sda;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;
  assign tick      = busy && (cnt == div_q);
  assign scl_oe    = !scl_lv;
  assign sda_oe    = !sda_lv;
  assign done      = done_q;
  assign rx_data   = rx_q;
  assign rx_nack   = rxn_q;

  always_comb begin
    last_ph = 3'd0;
    last_bn = 4'd0;
    case (op_q)
      OP_START, OP_STOP: last_ph = 3'd3;
      OP_WRITE: begin last_ph = (bn == ACK_BN) ? 3'd4 : 3'd3; last_bn = ACK_BN; end
      OP_READ:  begin last_ph = (bn == ACK_BN) ? 3'd4 : 3'd2; last_bn = ACK_BN; end
      OP_CLEAR: begin last_ph = 3'd3; last_bn = STOP_BN; end
      default: ;
    endcase
  end

  assign grp_end = (ph == last_ph);
  assign finish  = tick && grp_end && (bn == last_bn);
  assign nxt_ph  = grp_end ? '0 : ph + 1'b1;
  assign nxt_bn  = grp_end ? bn + 1'b1 : bn;

  assign enter  = accept || (tick && !finish);
  assign e_op   = accept ? cmd_op   : op_q;
  assign e_bn   = accept ? '0       : nxt_bn;
  assign e_ph   = accept ? '0       : nxt_ph;
  assign e_tx   = accept ? cmd_data : tx_q;
  assign e_nack = accept ? cmd_nack : nack_q;

  always_comb begin
    set_scl = 1'b0; val_scl = 1'b1;
    set_sda = 1'b0; val_sda = 1'b1;
    if (e_op == OP_STOP || (e_op == OP_CLEAR && e_bn == STOP_BN)) begin
      case (e_ph)
        3'd0: begin set_scl = 1'b1; val_scl = 1'b0; end
        3'd1: begin set_sda = 1'b1; val_sda = 1'b0; end
        3'd2: begin set_scl = 1'b1; val_scl = 1'b1; end
        3'd3: begin set_sda = 1'b1; val_sda = 1'b1; end
        default: ;
      endcase
    end else begin
      case (e_op)
        OP_START: begin
          case (e_ph)
            3'd1: begin set_sda = 1'b1; val_sda = 1'b1; end
            3'd2: begin set_scl = 1'b1; val_scl = 1'b1; end
            3'd3: begin set_sda = 1'b1; val_sda = 1'b0; end
            default: ;
          endcase
        end
        OP_WRITE: begin
          case (e_ph)
            3'd0: begin set_scl = 1'b1; val_scl = 1'b0; end
            3'd1: begin
              set_sda = 1'b1;
              val_sda = (e_bn < ACK_BN) ? e_tx[3'd7 - e_bn[2:0]] : 1'b1;
            end
            3'd2: begin set_scl = 1'b1; val_scl = 1'b1; end
            3'd4: begin set_scl = 1'b1; val_scl = 1'b0; end
            default: ;
          endcase
        end
        OP_READ: begin
          if (e_bn < ACK_BN) begin
            case (e_ph)
              3'd0: begin set_scl = 1'b1; val_scl = 1'b0; set_sda = 1'b1; val_sda = 1'b1; end
              3'd1: begin set_scl = 1'b1; val_scl = 1'b1; end
              default: ;
            endcase
          end else begin
            case (e_ph)
              3'd0: begin set_scl = 1'b1; val_scl = 1'b0; end
              3'd1: begin set_sda = 1'b1; val_sda = e_nack; end
              3'd2: begin set_scl = 1'b1; val_scl = 1'b1; end
              3'd4: begin set_scl = 1'b1; val_scl = 1'b0; end
              default: ;
            endcase
          end
        end
        OP_CLEAR: begin
          case (e_ph)
            3'd0: begin set_scl = 1'b1; val_scl = 1'b0; set_sda = 1'b1; val_sda = 1'b1; end
            3'd2: begin set_scl = 1'b1; val_scl = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      tx_q   <= '0;
      nack_q <= 1'b0;
      div_q  <= '0;
      cnt    <= '0;
      bn     <= '0;
      ph     <= '0;
      rx_q   <= '0;
      rxn_q  <= 1'b0;
      scl_lv <= 1'b1;
      sda_lv <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= cmd_op;
        tx_q   <= cmd_data;
        nack_q <= cmd_nack;
        div_q  <= quarter_div;
        cnt    <= '0;
        bn     <= '0;
        ph     <= '0;
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          if (op_q == OP_READ && bn < ACK_BN && ph == 3'd1) rx_q <= {rx_q[6:0], sda_in};
          if (op_q == OP_WRITE && bn == ACK_BN && ph == 3'd3) rxn_q <= sda_in;
          if (finish) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bn <= nxt_bn;
            ph <= nxt_ph;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (enter && set_scl) scl_lv <= val_scl;
      if (enter && set_sda) sda_lv <= val_sda;
    end
  end

  assert_lines_on_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick || accept) |=> ($stable(scl_oe) && $stable(sda_oe)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_start_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_START) |-> (!scl_oe && sda_oe));

  assert_stop_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_STOP) |-> (!scl_oe && !sda_oe));

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_WRITE || op_q == OP_READ) && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe));

  assert_clear_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_CLEAR) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_nack = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic [11:0] quarter_div = '0;
  logic       slave_rel = 1'b1;
  logic       cmd_ready, scl_oe, sda_oe, done, rx_nack, sda_in;
  logic [7:0] rx_data;

  int compared = 0;
  int mismatched = 0;
  logic [2:0] slots[$];
  bit cs = 1'b1;
  bit cd = 1'b1;

  always #2.5 clk = ~clk;

  assign sda_in = slave_rel & ~sda_oe;

  i2c_bit_engine #(.DIV_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .quarter_div(quarter_div), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .done(done), .rx_data(rx_data), .rx_nack(rx_nack)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic push(input bit v);
    slots.push_back({cs, cd, v});
  endtask

  task automatic stop_seq();
    cs = 1'b0; push(1'b1);
    cd = 1'b0; push(1'b1);
    cs = 1'b1; push(1'b1);
    cd = 1'b1; push(1'b1);
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] d, input bit flag, input int div, input string tag);
    logic [2:0] e;
    slots.delete();
    e = '0;
    case (op)
      3'd0: begin push(1'b1); cd = 1'b1; push(1'b1); cs = 1'b1; push(1'b1); cd = 1'b0; push(1'b1); end
      3'd1: stop_seq();
      3'd2: begin
        for (int i = 7; i >= 0; i--) begin
          cs = 1'b0; push(1'b1); cd = d[i]; push(1'b1); cs = 1'b1; push(1'b1); push(1'b1);
        end
        cs = 1'b0; push(flag); cd = 1'b1; push(flag); cs = 1'b1; push(flag); push(flag);
        cs = 1'b0; push(flag);
      end
      3'd3: begin
        for (int i = 7; i >= 0; i--) begin
          cs = 1'b0; cd = 1'b1; push(d[i]); cs = 1'b1; push(d[i]); push(d[i]);
        end
        cs = 1'b0; push(1'b1); cd = flag; push(1'b1); cs = 1'b1; push(1'b1); push(1'b1);
        cs = 1'b0; push(1'b1);
      end
      3'd4: begin
        for (int p = 0; p < 9; p++) begin
          cs = 1'b0; cd = 1'b1; push(1'b1); push(1'b1); cs = 1'b1; push(1'b1); push(1'b1);
        end
        stop_seq();
      end
      default: push(1'b1);
    endcase
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R3", "ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_nack = flag; quarter_div = 12'(div);
    for (int i = 0; i < slots.size(); i++) begin
      e = slots[i];
      for (int q = 0; q <= div; q++) begin
        @(negedge clk);
        cmd_valid = 1'b0;
        slave_rel = e[0];
        chk(scl_oe == !e[2], $sformatf("R1 %s", tag), "scl_oe", int'(scl_oe), int'(!e[2]));
        chk(sda_oe == !e[1], $sformatf("R1 %s", tag), "sda_oe", int'(sda_oe), int'(!e[1]));
        chk(done == 1'b0, "R3", "done early", int'(done), 0);
        chk(cmd_ready == 1'b0, "R3", "ready while busy", int'(cmd_ready), 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b1, $sformatf("R1 R3 %s", tag), "done due", int'(done), 1);
    chk(cmd_ready == 1'b1, "R3", "ready with done", int'(cmd_ready), 1);
    chk(scl_oe == !e[2], tag, "final scl_oe", int'(scl_oe), int'(!e[2]));
    chk(sda_oe == !e[1], tag, "final sda_oe", int'(sda_oe), int'(!e[1]));
    if (op == 3'd2) chk(rx_nack == flag, tag, "rx_nack", int'(rx_nack), int'(flag));
    if (op == 3'd3) chk(rx_data == d, tag, "rx_data", int'(rx_data), int'(d));
    slave_rel = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R3", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R2", "lines released idle", int'({scl_oe, sda_oe}), 0);
      chk(cmd_ready == 1'b1 && done == 1'b0, "R2", "idle handshake", int'({cmd_ready, done}), 2);
      chk(rx_data == 8'h00 && rx_nack == 1'b0, "R2", "rx reset", int'({rx_data, rx_nack}), 0);
    end
    run(3'd4, 8'h00, 1'b0, 0, "R10");
    run(3'd0, 8'h00, 1'b0, 1, "R4");
    run(3'd2, 8'hA5, 1'b0, 1, "R6 R7");
    run(3'd2, 8'h3C, 1'b1, 0, "R7");
    run(3'd3, 8'h96, 1'b0, 2, "R8 R9");
    run(3'd3, 8'h5A, 1'b1, 0, "R8 R9");
    run(3'd1, 8'h00, 1'b0, 1, "R5");
    run(3'd5, 8'hFF, 1'b0, 2, "R11");
    run(3'd0, 8'h00, 1'b0, 3, "R4");
    run(3'd7, 8'h00, 1'b1, 0, "R11");
    run(3'd2, 8'h81, 1'b0, 0, "R6");
    run(3'd1, 8'h00, 1'b0, 0, "R5");
    run(3'd4, 8'h00, 1'b0, 1, "R10");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule